// File: doc/BRIEF.md
# USB Device-Mode State Controller

This block decides whether the device side of a USB controller sits in its Reset state or in its low-power Idle state. It watches a controller-enable bit and the level of the ID pin, and falls back to Reset whenever either one leaves the device-role value. While in Reset it keeps the macro clock frozen, holds the endpoint banks deallocated, forces the detach flag so that neither data line is pulled up, and emits a single-cycle strobe that clears the device-mode registers.

In Idle the block drives the D+ or D- pull-up from the software detach bit, VBus presence and the selected speed. It also holds the enable bits of the eight endpoints. Endpoint 0, the default control endpoint, is always on outside Reset. Endpoints 1 to 7 are loaded by software writes. A USB bus reset, seen as a clean synchronous pulse, switches endpoints 1 to 7 off and leaves endpoint 0 on. Line-level reset detection, the PHY and the packet engine sit outside this block.

Top module: `usbd_mode_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block goes to Reset: dev_state 0, clk_freeze 1, bank_dealloc 1, reg_clear 1, pu_dp and pu_dm 0, ep_enable all zero.
- R2: In Reset, ctrl_en = 1 together with id_dev = 1 at a clock edge moves dev_state to 1 (Idle) after that edge.
- R3: In any state, ctrl_en = 0 or id_dev = 0 at a clock edge puts dev_state at 0 (Reset) after that edge.
- R4: reg_clear is 1 for exactly one cycle on each entry into Reset, in the first cycle dev_state reads 0, and is 0 at all other times after the hardware reset.
- R5: clk_freeze, bank_dealloc and detach_eff are 1 in Reset. In Idle, clk_freeze and bank_dealloc are 0 and detach_eff follows sw_detach in the same cycle.
- R6: The pull-up outputs are registered. One clock after a set of inputs is sampled, pu_dp is 1 only when detach_eff was 0, vbus_on was 1 and speed_sel was not 01. pu_dm is 1 only when detach_eff was 0, vbus_on was 1 and speed_sel was 01. The speed codes are 00 full, 01 low, 10 high, and 11 is handled like full. The two pull-ups are never both 1.
- R7: ep_enable[0] is 1 exactly when dev_state is 1. In Reset, ep_enable[7:1] are 0, and endpoint writes are ignored.
- R8: In Idle with no bus reset, ep_wr = 1 loads ep_wdata into ep_enable[7:1] after the clock edge.
- R9: In Idle, bus_reset = 1 clears ep_enable[7:1] after the clock edge and leaves ep_enable[0] at 1. It takes precedence over a write in the same cycle.
- R10: A bus_reset pulse in Reset changes no output.
- R11: Leaving Idle clears ep_enable[7:1], so on the next entry into Idle only endpoint 0 is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| ctrl_en | input | 1 | Controller enable bit |
| id_dev | input | 1 | ID pin level, 1 = device role |
| sw_detach | input | 1 | Software detach bit |
| vbus_on | input | 1 | VBus present, synchronous |
| speed_sel | input | 2 | 00 full, 01 low, 10 high, 11 as full |
| bus_reset | input | 1 | One-cycle USB bus reset event |
| ep_wr | input | 1 | Endpoint-enable write strobe |
| ep_wdata | input | 7 | New enables for endpoints 7..1 |
| dev_state | output | 1 | 0 Reset, 1 Idle |
| clk_freeze | output | 1 | Macro clock frozen |
| reg_clear | output | 1 | Register-clear strobe |
| bank_dealloc | output | 1 | Endpoint banks held deallocated |
| detach_eff | output | 1 | Effective detach flag |
| pu_dp | output | 1 | D+ pull-up enable |
| pu_dm | output | 1 | D- pull-up enable |
| ep_enable | output | 8 | Endpoint enables, bit 0 control endpoint |

## Verification
dev_state, reg_clear and ep_enable respond one clock edge after the inputs that cause them. The pull-ups respond one edge after the detach, VBus and speed inputs, which puts them two edges after an enable or ID change. clk_freeze, bank_dealloc and detach_eff follow the current state in the same cycle. The bench drives inputs at the falling edge and keeps a cycle model that advances at the rising edge. It compares every output at the next falling edge, so each expected value is checked in the cycle it is due.

// File: rtl/usbd_mode_pkg.sv
// Shared definitions for the device-mode state controller.
// Assumes a single clock domain and clean synchronous inputs.
package usbd_mode_pkg;

    typedef enum logic {
        ST_RESET = 1'b0,
        ST_IDLE  = 1'b1
    } dev_state_e;

    localparam int SPEED_W = 2;
    localparam logic [SPEED_W-1:0] SPD_FULL = 2'b00;
    localparam logic [SPEED_W-1:0] SPD_LOW  = 2'b01;
    localparam logic [SPEED_W-1:0] SPD_HIGH = 2'b10;

endpackage

// File: rtl/usbd_mode_fsm.sv
// Reset/Idle sequencer. It moves to Idle when enable and ID both indicate
// the device role. It goes back to Reset as soon as either one drops, and
// it pulses reg_clear once per entry into Reset.
// Assumes ctrl_en and id_dev are already synchronous to clk.
module usbd_mode_fsm
    import usbd_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_en,
    input  logic id_dev,
    output logic in_idle,
    output logic going_reset,
    output logic reg_clear
);

    dev_state_e state_q;
    dev_state_e state_d;
    logic       clear_q;

    // Leaving device mode: either condition is enough.
    always_comb begin
        going_reset = !ctrl_en || !id_dev;
    end

    // Next-state selection.
    always_comb begin
        if (going_reset) begin
            state_d = ST_RESET;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Register-clear strobe: one cycle on each Idle-to-Reset entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clear_q <= 1'b1;
        end else begin
            clear_q <= (state_q == ST_IDLE) && going_reset;
        end
    end

    assign in_idle   = (state_q == ST_IDLE);
    assign reg_clear = clear_q;

    // R3
    leave_device_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en || !id_dev) |=> !in_idle);

    // R2
    enter_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_idle && ctrl_en && id_dev) |=> in_idle);

    // R4
    clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clear |=> !reg_clear);

    // R4
    clear_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clear |-> !in_idle);

endmodule

// File: rtl/usbd_pullup_sel.sv
// Pull-up selector. It registers the D+/D- pull-up enables from the
// effective detach flag, VBus presence and the speed code. Low speed takes
// D-, every other code takes D+.
// Assumes vbus_on and speed_sel are synchronous to clk.
module usbd_pullup_sel
    import usbd_mode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               detach_eff,
    input  logic               vbus_on,
    input  logic [SPEED_W-1:0] speed_sel,
    output logic               pu_dp,
    output logic               pu_dm
);

    logic attach_ok;
    logic low_speed;
    logic dp_q;
    logic dm_q;

    // Attach is allowed only when not detached and VBus is present.
    always_comb begin
        attach_ok = !detach_eff && vbus_on;
        low_speed = (speed_sel == SPD_LOW);
    end

    // Registered pull-up enables, both off in hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= 1'b0;
            dm_q <= 1'b0;
        end else begin
            dp_q <= attach_ok && !low_speed;
            dm_q <= attach_ok && low_speed;
        end
    end

    assign pu_dp = dp_q;
    assign pu_dm = dm_q;

    // R6
    pullup_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pu_dp, pu_dm}));

    // R6
    detached_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detach_eff || !vbus_on) |=> (!pu_dp && !pu_dm));

endmodule

// File: rtl/usbd_ep_enables.sv
// Endpoint enable register. Endpoint 0 is on whenever the block is in
// Idle. The upper endpoints load from software writes, are cleared by a
// bus reset while in Idle, and are cleared on every entry into Reset.
// Assumes bus_reset is a clean one-cycle synchronous pulse.
module usbd_ep_enables #(
    parameter int NUM_EP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_idle,
    input  logic              going_reset,
    input  logic              bus_reset,
    input  logic              ep_wr,
    input  logic [NUM_EP-1:1] ep_wdata,
    output logic [NUM_EP-1:0] ep_enable
);

    localparam int CFG_EP = NUM_EP - 1;

    logic [NUM_EP-1:1] cfg_q;
    logic              wipe;
    logic              load;

    // Clear when in or entering Reset, or on a bus reset. A write loads only
    // when neither applies.
    always_comb begin
        wipe = going_reset || !in_idle || bus_reset;
        load = ep_wr && !wipe;
    end

    // One flop per configurable endpoint.
    generate
        for (genvar e = 1; e <= CFG_EP; e++) begin : g_ep
            // Enable flop for endpoint e.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[e] <= 1'b0;
                end else if (wipe) begin
                    cfg_q[e] <= 1'b0;
                end else if (load) begin
                    cfg_q[e] <= ep_wdata[e];
                end
            end
        end
    endgenerate

    assign ep_enable = {cfg_q, in_idle};

    // R7
    reset_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_idle |-> (ep_enable == '0));

    // R9
    bus_reset_keep_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && in_idle && !going_reset) |=> (ep_enable[NUM_EP-1:1] == '0 && ep_enable[0]));

    // R8
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_wr && in_idle && !going_reset && !bus_reset) |=> (ep_enable[NUM_EP-1:1] == $past(ep_wdata)));

endmodule

// File: rtl/usbd_mode_ctrl.sv
// Top level of the device-mode state controller. It ties the Reset/Idle
// sequencer, the pull-up selector and the endpoint enable register
// together and derives the frozen-clock, bank-deallocation and detach flags
// from the current state.
// Assumes every input is synchronous to clk.
module usbd_mode_ctrl
    import usbd_mode_pkg::*;
#(
    parameter int NUM_EP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              id_dev,
    input  logic              sw_detach,
    input  logic              vbus_on,
    input  logic [SPEED_W-1:0] speed_sel,
    input  logic              bus_reset,
    input  logic              ep_wr,
    input  logic [NUM_EP-1:1] ep_wdata,
    output logic              dev_state,
    output logic              clk_freeze,
    output logic              reg_clear,
    output logic              bank_dealloc,
    output logic              detach_eff,
    output logic              pu_dp,
    output logic              pu_dm,
    output logic [NUM_EP-1:0] ep_enable
);

    logic in_idle;
    logic going_reset;

    usbd_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_en     (ctrl_en),
        .id_dev      (id_dev),
        .in_idle     (in_idle),
        .going_reset (going_reset),
        .reg_clear   (reg_clear)
    );

    // State-derived flags: Reset freezes, deallocates and detaches.
    always_comb begin
        clk_freeze   = !in_idle;
        bank_dealloc = !in_idle;
        detach_eff   = !in_idle || sw_detach;
    end

    usbd_pullup_sel u_pullup (
        .clk        (clk),
        .rst_n      (rst_n),
        .detach_eff (detach_eff),
        .vbus_on    (vbus_on),
        .speed_sel  (speed_sel),
        .pu_dp      (pu_dp),
        .pu_dm      (pu_dm)
    );

    usbd_ep_enables #(.NUM_EP(NUM_EP)) u_ep (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_idle     (in_idle),
        .going_reset (going_reset),
        .bus_reset   (bus_reset),
        .ep_wr       (ep_wr),
        .ep_wdata    (ep_wdata),
        .ep_enable   (ep_enable)
    );

    assign dev_state = in_idle;

    // R5
    reset_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_state |-> (clk_freeze && bank_dealloc && detach_eff));

    // R10
    bus_reset_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_state && bus_reset && !ctrl_en) |=> (ep_enable == '0 && !dev_state));

endmodule

// File: tb/usbd_mode_ctrl_test.sv
// Self-checking bench. Inputs change at the falling edge, a cycle model
// advances at the rising edge, and outputs are compared at the next
// falling edge.
module usbd_mode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_en = 1'b0, id_dev = 1'b0, sw_detach = 1'b0, vbus_on = 1'b0;
    logic [1:0] speed_sel = 2'b00;
    logic       bus_reset = 1'b0, ep_wr = 1'b0;
    logic [7:1] ep_wdata = '0;
    logic       dev_state, clk_freeze, reg_clear, bank_dealloc, detach_eff, pu_dp, pu_dm;
    logic [7:0] ep_enable;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    logic       m_st, m_rc, m_dp, m_dm;
    logic [7:1] m_ep;

    always #5 clk = ~clk;

    usbd_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .id_dev(id_dev),
        .sw_detach(sw_detach), .vbus_on(vbus_on), .speed_sel(speed_sel),
        .bus_reset(bus_reset), .ep_wr(ep_wr), .ep_wdata(ep_wdata),
        .dev_state(dev_state), .clk_freeze(clk_freeze), .reg_clear(reg_clear),
        .bank_dealloc(bank_dealloc), .detach_eff(detach_eff),
        .pu_dp(pu_dp), .pu_dm(pu_dm), .ep_enable(ep_enable)
    );

    // Cycle model built from the requirements.
    always @(posedge clk) begin
        logic leave, det;
        leave = !ctrl_en || !id_dev;
        det   = (m_st == 1'b0) ? 1'b1 : sw_detach;
        if (!rst_n) begin
            m_st <= 1'b0; m_rc <= 1'b1; m_dp <= 1'b0; m_dm <= 1'b0; m_ep <= '0;
        end else begin
            m_st <= !leave;
            m_rc <= m_st && leave;
            m_dp <= !det && vbus_on && (speed_sel != 2'b01);
            m_dm <= !det && vbus_on && (speed_sel == 2'b01);
            if (leave || !m_st || bus_reset) m_ep <= '0;
            else if (ep_wr) m_ep <= ep_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 R3 dev_state", dev_state, m_st);
        chk("R4 reg_clear", reg_clear, m_rc);
        chk("R5 clk_freeze", clk_freeze, !m_st);
        chk("R5 bank_dealloc", bank_dealloc, !m_st);
        chk("R5 detach_eff", detach_eff, m_st ? sw_detach : 1'b1);
        chk("R6 pu_dp", pu_dp, m_dp);
        chk("R6 pu_dm", pu_dm, m_dm);
        chk("R7 R8 R9 ep_enable", ep_enable, {m_ep, m_st});
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #1_500_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [7:0] hold;
        step(); step();
        // R1: hardware reset state
        chk("R1 dev_state", dev_state, 0);
        chk("R1 clk_freeze", clk_freeze, 1);
        chk("R1 bank_dealloc", bank_dealloc, 1);
        chk("R1 reg_clear", reg_clear, 1);
        chk("R1 pullups", {pu_dp, pu_dm}, 0);
        chk("R1 ep_enable", ep_enable, 0);
        rst_n = 1; ctrl_en = 1; id_dev = 1; vbus_on = 1; sw_detach = 0; speed_sel = 2'b00;
        step();
        chk("R2 idle entry", dev_state, 1);
        chk("R4 no strobe after reset", reg_clear, 0);
        chk("R7 ep0 on in idle", ep_enable, 8'h01);
        step();
        chk("R6 full speed D+", {pu_dp, pu_dm}, 2'b10);
        ep_wr = 1; ep_wdata = 7'h55;
        step();
        chk("R8 write load", ep_enable, 8'hAB);
        ep_wdata = 7'h7F; bus_reset = 1;
        step();
        chk("R9 bus reset over write", ep_enable, 8'h01);
        bus_reset = 0; ep_wdata = 7'h0F;
        step();
        chk("R8 second write", ep_enable, 8'h1F);
        ep_wr = 0; speed_sel = 2'b10;
        step();
        chk("R6 high speed D+", {pu_dp, pu_dm}, 2'b10);
        ctrl_en = 0;
        step();
        chk("R3 enable drop", dev_state, 0);
        chk("R4 strobe on entry", reg_clear, 1);
        chk("R11 cleared on leave", ep_enable, 0);
        hold = ep_enable;
        bus_reset = 1; ep_wr = 1; ep_wdata = 7'h7F;
        step();
        chk("R4 strobe single", reg_clear, 0);
        chk("R6 detached in reset", {pu_dp, pu_dm}, 0);
        chk("R10 bus reset ignored state", dev_state, 0);
        chk("R10 bus reset ignored ep", ep_enable, hold);
        chk("R7 write ignored in reset", ep_enable, 0);
        bus_reset = 0; ep_wr = 0; ctrl_en = 1; speed_sel = 2'b01;
        step();
        chk("R11 re-entry only ep0", ep_enable, 8'h01);
        step();
        chk("R6 low speed D-", {pu_dp, pu_dm}, 2'b01);
        id_dev = 0;
        step();
        chk("R3 ID drop", dev_state, 0);
        chk("R4 strobe on ID drop", reg_clear, 1);
        id_dev = 1; sw_detach = 1;
        step();
        step();
        chk("R5 detach follows bit", detach_eff, 1);
        chk("R6 detached no pull", {pu_dp, pu_dm}, 0);
        // Sweep: pseudo-random inputs, biased toward device role.
        lfsr = 16'hACE1;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            check_all();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ctrl_en   = lfsr[0] | lfsr[1] | lfsr[2];
            id_dev    = lfsr[3] | lfsr[4] | lfsr[5];
            sw_detach = lfsr[6] & lfsr[7];
            vbus_on   = lfsr[8] | lfsr[9];
            speed_sel = lfsr[11:10];
            bus_reset = lfsr[12] & lfsr[13];
            ep_wr     = lfsr[14];
            ep_wdata  = {lfsr[15], lfsr[5:0]} ^ cyc[6:0];
            rst_n     = (cyc % 997) != 500;
            step();
        end
        check_all();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule